// File: doc/BRIEF.md
# Parallel-Port Bridge Block Transfer Engine

This engine runs a counted block of bytes between a host-side byte stream and the data register of a parallel-port disk bridge. Software or a controller gives it a direction, a byte count and one of six port modes. The engine then issues the port operations for that mode one per clock: a fixed preamble, a short group of operations for every byte, and a fixed postamble. Three of the modes are narrow, meaning a byte moves over status lines, a 5/3 split or the data lines. The other three are enhanced-parallel-port modes, and at byte level they behave the same way.

In the narrow modes a phase bit goes into the strobe pattern and changes after every byte. Narrow writes skip the data-line update when a byte equals the one already on the lines. Long enhanced reads and short enhanced writes need a side register of the bridge set before the block and cleared after it. The engine asks a separate register sequencer to make that write. Read bytes leave on a valid/ready stream and write bytes arrive on one. Either stream can hold back the port sequence.

Top module: `pbridge_xfer`

## Requirements
- R1: `start_i` is taken only while `busy_o` is low and `mode_i` is 0 to 5, where 0 is nibble, 1 is 5/3, 2 is byte and 3, 4 and 5 are enhanced modes. Any other mode leaves the engine idle and issues no operation. Operation codes on `pop_kind_o`: 0 put data lines, 1 put control lines, 2 enhanced address write, 3 enhanced data write, 4 get status, 5 get control readback, 6 get data lines, 7 enhanced data read. The value field is 0 for every get.
- R2: A nibble read issues data 0x81, control 0x01, control 0x03 and data 0xC1. For each byte it then issues control 0x02|ph, get status, control 0x04|ph and get status. The byte is {second status[7:4], first status[7:4]}. The block ends with data 0x00 and control 0x04.
- R3: A 5/3 read issues data 0x91, control 0x01, data 0x10, control 0x03, data 0x51, control 0x05 and data 0xD1. For each byte it issues control 0x04|ph, get status and get control. The byte is {control[3:1], status[7:3]}. The block ends with data 0x00 and control 0x04.
- R4: A byte read issues data 0x89 and then control 0x01, 0x23 and 0x21. For each byte it issues control 0x24|ph and get data, and the byte is the sampled data lines. The block ends with control 0x06 and then 0x04.
- R5: The phase bit ph starts at 1 for reads and at 0 for writes, and it inverts after each byte.
- R6: A narrow write (modes 0 to 2) issues data 0xA1 and then control 0x01, 0x03, 0x01 and 0x05. For each byte it issues control 0x04|ph. The block ends with control 0x07 and then 0x04.
- R7: During a narrow write a byte's data-line put is left out when the byte equals the previous byte of the same block. The first byte of a block is always put.
- R8: An enhanced read issues an address write of 0x00 and then control 0x24. It issues one enhanced data read per byte and ends with control 0x04. If the count is above 512, side register 0x84 is set to 3 before the address write. After the final control, 0x84 is always set to 0.
- R9: An enhanced write issues an address write of 0x40 and then one enhanced data write per byte. If the count is below 512, side register 0x84 is set to 1 before the address write and to 0 after the last byte.
- R10: A read byte stays on `rd_data_o` with `rd_valid_o` high until it is taken. No port operation is issued while it waits.
- R11: A write byte is accepted only between per-byte groups. No port operation is issued while the engine waits for `wr_valid_i`.
- R12: `sreg_req_o` stays high with a stable address and value until `sreg_ack_i`. It is never high in the same cycle as a port operation.
- R13: `done_o` pulses for exactly one cycle, on the cycle after the last port operation or side write of the block. A count of 0 issues only the preamble, the postamble and the side writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a block |
| dir_i | input | 1 | 1 = write to bridge, 0 = read |
| mode_i | input | 3 | Port mode 0..5 |
| count_i | input | CNT_W | Byte count |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Read stream byte |
| rd_valid_o | output | 1 | Read stream valid |
| rd_ready_i | input | 1 | Read stream ready |
| wr_data_i | input | 8 | Write stream byte |
| wr_valid_i | input | 1 | Write stream valid |
| wr_ready_o | output | 1 | Write stream ready |
| pop_valid_o | output | 1 | Port operation this cycle |
| pop_kind_o | output | 3 | Port operation code |
| pop_val_o | output | 8 | Value for put and write operations |
| pin_data_i | input | 8 | Data-line readback |
| pin_stat_i | input | 8 | Status lines |
| pin_ctrl_i | input | 8 | Control-line readback |
| pin_epp_i | input | 8 | Enhanced data read value |
| sreg_req_o | output | 1 | Side-register write request |
| sreg_addr_o | output | 8 | Side-register address |
| sreg_val_o | output | 8 | Side-register value |
| sreg_ack_i | input | 1 | Side-register write done |

## Verification
Every internal state of this engine maps onto the operation it puts on the port in a given cycle. A wrong step index, a wrong phase bit or a stale repeat filter therefore shows as a wrong code or value in the operation trace. It shows in the first cycle of the affected group, and at the latest on the next byte. A wrong sampling step shows as a wrong byte on the read stream one handshake later. A wrong side-register decision shows as a missing or extra request next to the address cycle. The bench compares the full trace against one built independently for each mode, direction and count boundary.

// File: rtl/px_pkg.sv
package px_pkg;

  typedef enum logic [2:0] {
    OP_PUT_DATA = 3'd0,
    OP_PUT_CTRL = 3'd1,
    OP_EPP_ADDR = 3'd2,
    OP_EPP_WR   = 3'd3,
    OP_GET_STAT = 3'd4,
    OP_GET_CTRL = 3'd5,
    OP_GET_DATA = 3'd6,
    OP_EPP_RD   = 3'd7
  } pop_e;

  typedef enum logic [1:0] {
    CL_NIB  = 2'd0,
    CL_53   = 2'd1,
    CL_BYTE = 2'd2,
    CL_EPP  = 2'd3
  } cls_e;

  typedef struct packed {
    pop_e       kind;
    logic [7:0] val;
  } pstep_t;

  localparam logic [2:0] MODE_LAST = 3'd5;

  function automatic pstep_t mk(input pop_e k, input logic [7:0] v);
    pstep_t s;
    s.kind = k;
    s.val  = v;
    return s;
  endfunction

  function automatic cls_e cls_of(input logic [2:0] m);
    case (m)
      3'd0:    return CL_NIB;
      3'd1:    return CL_53;
      3'd2:    return CL_BYTE;
      default: return CL_EPP;
    endcase
  endfunction

  function automatic logic [2:0] pre_len(input cls_e c, input logic wr);
    if (wr) return (c == CL_EPP) ? 3'd1 : 3'd5;
    case (c)
      CL_53:   return 3'd7;
      CL_EPP:  return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic pstep_t pre_step(input cls_e c, input logic wr, input logic [2:0] i);
    if (wr) begin
      if (c == CL_EPP) return mk(OP_EPP_ADDR, 8'h40);
      case (i)
        3'd0:    return mk(OP_PUT_DATA, 8'hA1);
        3'd1:    return mk(OP_PUT_CTRL, 8'h01);
        3'd2:    return mk(OP_PUT_CTRL, 8'h03);
        3'd3:    return mk(OP_PUT_CTRL, 8'h01);
        default: return mk(OP_PUT_CTRL, 8'h05);
      endcase
    end
    case (c)
      CL_NIB: case (i)
        3'd0:    return mk(OP_PUT_DATA, 8'h81);
        3'd1:    return mk(OP_PUT_CTRL, 8'h01);
        3'd2:    return mk(OP_PUT_CTRL, 8'h03);
        default: return mk(OP_PUT_DATA, 8'hC1);
      endcase
      CL_53: case (i)
        3'd0:    return mk(OP_PUT_DATA, 8'h91);
        3'd1:    return mk(OP_PUT_CTRL, 8'h01);
        3'd2:    return mk(OP_PUT_DATA, 8'h10);
        3'd3:    return mk(OP_PUT_CTRL, 8'h03);
        3'd4:    return mk(OP_PUT_DATA, 8'h51);
        3'd5:    return mk(OP_PUT_CTRL, 8'h05);
        default: return mk(OP_PUT_DATA, 8'hD1);
      endcase
      CL_BYTE: case (i)
        3'd0:    return mk(OP_PUT_DATA, 8'h89);
        3'd1:    return mk(OP_PUT_CTRL, 8'h01);
        3'd2:    return mk(OP_PUT_CTRL, 8'h23);
        default: return mk(OP_PUT_CTRL, 8'h21);
      endcase
      default: return (i == 3'd0) ? mk(OP_EPP_ADDR, 8'h00) : mk(OP_PUT_CTRL, 8'h24);
    endcase
  endfunction

  function automatic logic [2:0] post_len(input cls_e c, input logic wr);
    if (c == CL_EPP) return wr ? 3'd0 : 3'd1;
    return 3'd2;
  endfunction

  function automatic pstep_t post_step(input cls_e c, input logic wr, input logic [2:0] i);
    if (i != 3'd0 || c == CL_EPP) return mk(OP_PUT_CTRL, 8'h04);
    if (wr) return mk(OP_PUT_CTRL, 8'h07);
    if (c == CL_BYTE) return mk(OP_PUT_CTRL, 8'h06);
    return mk(OP_PUT_DATA, 8'h00);
  endfunction

  function automatic logic [1:0] byte_last(input cls_e c, input logic wr);
    if (c == CL_EPP) return 2'd0;
    if (wr) return 2'd1;
    case (c)
      CL_NIB:  return 2'd3;
      CL_53:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic pstep_t byte_step(input cls_e c, input logic wr, input logic [1:0] u,
                                       input logic ph, input logic [7:0] wb);
    logic [7:0] p;
    p = {7'd0, ph};
    if (wr) begin
      if (c == CL_EPP) return mk(OP_EPP_WR, wb);
      return (u == 2'd0) ? mk(OP_PUT_DATA, wb) : mk(OP_PUT_CTRL, 8'h04 | p);
    end
    case (c)
      CL_NIB: case (u)
        2'd0:    return mk(OP_PUT_CTRL, 8'h02 | p);
        2'd2:    return mk(OP_PUT_CTRL, 8'h04 | p);
        default: return mk(OP_GET_STAT, 8'h00);
      endcase
      CL_53: case (u)
        2'd0:    return mk(OP_PUT_CTRL, 8'h04 | p);
        2'd1:    return mk(OP_GET_STAT, 8'h00);
        default: return mk(OP_GET_CTRL, 8'h00);
      endcase
      CL_BYTE: return (u == 2'd0) ? mk(OP_PUT_CTRL, 8'h24 | p) : mk(OP_GET_DATA, 8'h00);
      default: return mk(OP_EPP_RD, 8'h00);
    endcase
  endfunction

endpackage

// File: rtl/px_byte_join.sv
module px_byte_join
  import px_pkg::*;
(
  input  cls_e       cls_i,
  input  logic [7:0] first_i,
  input  logic [7:0] last_i,
  output logic [7:0] byte_o
);
  always_comb begin
    case (cls_i)
      CL_NIB:  byte_o = {last_i[7:4], first_i[7:4]};
      CL_53:   byte_o = {last_i[3:1], first_i[7:3]};
      default: byte_o = last_i;
    endcase
  end
endmodule

// File: rtl/px_repeat_filter.sv
module px_repeat_filter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          take_i,
  input  logic [DW-1:0] din_i,
  output logic          rpt_o
);
  logic          fresh_q, fresh_d;
  logic [DW-1:0] prev_q, prev_d;
  logic          en;

  assign rpt_o = !fresh_q && (din_i == prev_q);
  assign en    = clr_i || take_i;

  always_comb begin
    fresh_d = clr_i ? 1'b1 : 1'b0;
    prev_d  = take_i ? din_i : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b1;
      prev_q  <= '0;
    end else if (en) begin
      fresh_q <= fresh_d;
      prev_q  <= prev_d;
    end
  end
endmodule

// File: rtl/pbridge_xfer.sv
module pbridge_xfer
  import px_pkg::*;
#(
  parameter int         CNT_W     = 16,
  parameter int         BLK_BYTES = 512,
  parameter logic [7:0] SIDE_ADDR = 8'h84
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic             pop_valid_o,
  output logic [2:0]       pop_kind_o,
  output logic [7:0]       pop_val_o,
  input  logic [7:0]       pin_data_i,
  input  logic [7:0]       pin_stat_i,
  input  logic [7:0]       pin_ctrl_i,
  input  logic [7:0]       pin_epp_i,
  output logic             sreg_req_o,
  output logic [7:0]       sreg_addr_o,
  output logic [7:0]       sreg_val_o,
  input  logic             sreg_ack_i
);
  localparam logic [CNT_W-1:0] BLK = CNT_W'(BLK_BYTES);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_SIDE_PRE, S_PRE, S_WAIT_IN, S_BYTE, S_OUT, S_POST, S_SIDE_POST, S_FIN
  } st_e;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  st_e              st_q, st_d;
  logic             wr_q, wr_d;
  cls_e             cls_q, cls_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [2:0]       idx_q, idx_d;
  logic [1:0]       us_q, us_d;
  logic             ph_q, ph_d;
  logic             spre_q, spre_d, spost_q, spost_d;
  logic [7:0]       sval_q, sval_d;
  logic [7:0]       samp_q, samp_d;
  logic [7:0]       rd_q, rd_d;
  logic [7:0]       wb_q, wb_d;

  pstep_t     cur;
  logic       cur_v;
  logic [7:0] sample, joined;
  logic       rpt, accept, take_in;
  cls_e       cls_in;
  logic       need_pre, need_post;
  st_e        tail_st;

  assign cls_in    = cls_of(mode_i);
  assign accept    = (st_q == S_IDLE) && start_i && (mode_i <= MODE_LAST);
  assign take_in   = (st_q == S_WAIT_IN) && wr_valid_i;
  assign need_pre  = (cls_in == CL_EPP) && (dir_i ? (count_i < BLK) : (count_i > BLK));
  assign need_post = (cls_in == CL_EPP) && (!dir_i || (count_i < BLK));
  assign tail_st   = (post_len(cls_q, wr_q) != 3'd0) ? S_POST :
                     (spost_q ? S_SIDE_POST : S_FIN);

  // operation decode from state
  always_comb begin
    cur   = mk(OP_PUT_DATA, 8'h00);
    cur_v = 1'b0;
    case (st_q)
      S_PRE:  begin cur = pre_step(cls_q, wr_q, idx_q);                  cur_v = 1'b1; end
      S_BYTE: begin cur = byte_step(cls_q, wr_q, us_q, ph_q, wb_q);      cur_v = 1'b1; end
      S_POST: begin cur = post_step(cls_q, wr_q, idx_q);                 cur_v = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    case (cur.kind)
      OP_GET_STAT: sample = pin_stat_i;
      OP_GET_CTRL: sample = pin_ctrl_i;
      OP_GET_DATA: sample = pin_data_i;
      default:     sample = pin_epp_i;
    endcase
  end

  px_byte_join u_join (
    .cls_i   (cls_q),
    .first_i (samp_q),
    .last_i  (sample),
    .byte_o  (joined)
  );

  px_repeat_filter #(.DW(8)) u_filt (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr_i  (accept),
    .take_i (take_in),
    .din_i  (wr_data_i),
    .rpt_o  (rpt)
  );

  // next state
  always_comb begin
    st_d = st_q;   wr_d = wr_q;     cls_d = cls_q;   rem_d = rem_q;
    idx_d = idx_q; us_d = us_q;     ph_d = ph_q;     spre_d = spre_q;
    spost_d = spost_q; sval_d = sval_q; samp_d = samp_q; rd_d = rd_q; wb_d = wb_q;
    case (st_q)
      S_IDLE: if (accept) begin
        wr_d    = dir_i;
        cls_d   = cls_in;
        rem_d   = count_i;
        idx_d   = 3'd0;
        ph_d    = !dir_i;
        spre_d  = need_pre;
        spost_d = need_post;
        sval_d  = dir_i ? 8'h01 : 8'h03;
        st_d    = need_pre ? S_SIDE_PRE : S_PRE;
      end
      S_SIDE_PRE: if (sreg_ack_i) st_d = S_PRE;
      S_PRE: begin
        if (idx_q == pre_len(cls_q, wr_q) - 3'd1) begin
          idx_d = 3'd0;
          us_d  = 2'd0;
          if (rem_q == '0) st_d = tail_st;
          else             st_d = wr_q ? S_WAIT_IN : S_BYTE;
        end else begin
          idx_d = idx_q + 3'd1;
        end
      end
      S_WAIT_IN: if (wr_valid_i) begin
        wb_d = wr_data_i;
        us_d = ((cls_q != CL_EPP) && rpt) ? 2'd1 : 2'd0;
        st_d = S_BYTE;
      end
      S_BYTE: begin
        if (us_q == byte_last(cls_q, wr_q)) begin
          if (!wr_q) begin
            rd_d = joined;
            st_d = S_OUT;
          end else begin
            rem_d = rem_q - ONE;
            ph_d  = !ph_q;
            st_d  = (rem_q == ONE) ? tail_st : S_WAIT_IN;
          end
        end else begin
          if (cur.kind[2]) samp_d = sample;
          us_d = us_q + 2'd1;
        end
      end
      S_OUT: if (rd_ready_i) begin
        rem_d = rem_q - ONE;
        ph_d  = !ph_q;
        us_d  = 2'd0;
        st_d  = (rem_q == ONE) ? tail_st : S_BYTE;
      end
      S_POST: begin
        if (idx_q == post_len(cls_q, wr_q) - 3'd1) st_d = spost_q ? S_SIDE_POST : S_FIN;
        else                                       idx_d = idx_q + 3'd1;
      end
      S_SIDE_POST: if (sreg_ack_i) st_d = S_FIN;
      S_FIN:       st_d = S_IDLE;
      default:     st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q <= S_IDLE;  wr_q <= 1'b0;  cls_q <= CL_NIB; rem_q <= '0;
      idx_q <= '0;     us_q <= '0;    ph_q <= 1'b0;    spre_q <= 1'b0;
      spost_q <= 1'b0; sval_q <= '0;  samp_q <= '0;    rd_q <= '0;  wb_q <= '0;
    end else begin
      st_q <= st_d;  wr_q <= wr_d;  cls_q <= cls_d;  rem_q <= rem_d;
      idx_q <= idx_d; us_q <= us_d; ph_q <= ph_d;    spre_q <= spre_d;
      spost_q <= spost_d; sval_q <= sval_d; samp_q <= samp_d; rd_q <= rd_d; wb_q <= wb_d;
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_FIN);
  assign rd_valid_o  = (st_q == S_OUT);
  assign rd_data_o   = rd_q;
  assign wr_ready_o  = (st_q == S_WAIT_IN);
  assign pop_valid_o = cur_v;
  assign pop_kind_o  = cur.kind;
  assign pop_val_o   = cur.val;
  assign sreg_req_o  = (st_q == S_SIDE_PRE) || (st_q == S_SIDE_POST);
  assign sreg_addr_o = SIDE_ADDR;
  assign sreg_val_o  = (st_q == S_SIDE_PRE && spre_q) ? sval_q : 8'h00;
endmodule

// File: rtl/pbridge_xfer_chk.sv
module pbridge_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       rd_valid_o,
  input logic       rd_ready_i,
  input logic [7:0] rd_data_o,
  input logic       wr_valid_i,
  input logic       wr_ready_o,
  input logic       pop_valid_o,
  input logic       sreg_req_o,
  input logic       sreg_ack_i,
  input logic [7:0] sreg_addr_o,
  input logic [7:0] sreg_val_o
);
  a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  a_r10_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));

  a_r10_no_op_while_out: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> !pop_valid_o);

  a_r11_no_op_while_starved: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_o && !wr_valid_i |-> !pop_valid_o);

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    sreg_req_o && !sreg_ack_i |=> sreg_req_o && $stable(sreg_addr_o) && $stable(sreg_val_o));

  a_r12_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sreg_req_o && pop_valid_o));

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind pbridge_xfer pbridge_xfer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rd_valid_o  (rd_valid_o),
  .rd_ready_i  (rd_ready_i),
  .rd_data_o   (rd_data_o),
  .wr_valid_i  (wr_valid_i),
  .wr_ready_o  (wr_ready_o),
  .pop_valid_o (pop_valid_o),
  .sreg_req_o  (sreg_req_o),
  .sreg_ack_i  (sreg_ack_i),
  .sreg_addr_o (sreg_addr_o),
  .sreg_val_o  (sreg_val_o)
);

// File: tb/pbridge_xfer_tb_top.sv
module pbridge_xfer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, dir_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [15:0] count_i = 16'd0;
  logic        busy_o, done_o, rd_valid_o, wr_ready_o, pop_valid_o, sreg_req_o;
  logic [7:0]  rd_data_o, pop_val_o, sreg_addr_o, sreg_val_o;
  logic [2:0]  pop_kind_o;
  logic        rd_ready_i = 1'b0, wr_valid_i = 1'b0, sreg_ack_i = 1'b0;
  logic [7:0]  wr_data_i = 8'h00;
  logic [7:0]  pin_data_i, pin_stat_i, pin_ctrl_i, pin_epp_i;

  always #5 clk = ~clk;

  pbridge_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i), .mode_i(mode_i),
    .count_i(count_i), .busy_o(busy_o), .done_o(done_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .wr_data_i(wr_data_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .pop_valid_o(pop_valid_o), .pop_kind_o(pop_kind_o), .pop_val_o(pop_val_o),
    .pin_data_i(pin_data_i), .pin_stat_i(pin_stat_i), .pin_ctrl_i(pin_ctrl_i),
    .pin_epp_i(pin_epp_i), .sreg_req_o(sreg_req_o), .sreg_addr_o(sreg_addr_o),
    .sreg_val_o(sreg_val_o), .sreg_ack_i(sreg_ack_i)
  );

  int n_chk = 0, n_fail = 0;
  int src [0:1023];
  int rx  [0:1023];
  int lg  [0:4095];
  int ex  [0:4095];
  int rx_n = 0, lg_n = 0, ex_n = 0;
  int cyc = 0, last_cyc = 0, done_cyc = 0, done_cnt = 0;
  int stall_err = 0, addr_err = 0, ack_w = 0;
  int wr_idx = 0, wr_n = 0, mode_cur = 0;
  bit gaps = 1'b0, wr_acc = 1'b0, hold_p = 1'b0;
  logic [7:0] hold_v = 8'h00, ctl_last = 8'h00, cur_b;

  // bridge model: presents the byte the consumer expects next
  always_comb begin
    cur_b      = src[rx_n & 1023][7:0];
    pin_data_i = cur_b;
    pin_epp_i  = cur_b;
    pin_ctrl_i = {4'h0, cur_b[7:5], 1'b0};
    if (mode_cur == 1)    pin_stat_i = {cur_b[4:0], 3'b000};
    else if (ctl_last[2]) pin_stat_i = {cur_b[7:4], 4'h0};
    else                  pin_stat_i = {cur_b[3:0], 4'h0};
  end

  // monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pop_valid_o) begin
      lg[lg_n] <= (int'(pop_kind_o) << 8) | int'(pop_val_o);
      lg_n     <= lg_n + 1;
      last_cyc <= cyc;
      if (pop_kind_o == 3'd1) ctl_last <= pop_val_o;
    end else if (sreg_req_o && sreg_ack_i) begin
      lg[lg_n] <= (8 << 8) | int'(sreg_val_o);
      lg_n     <= lg_n + 1;
      last_cyc <= cyc;
      if (sreg_addr_o != 8'h84) addr_err <= addr_err + 1;
    end
    if (rd_valid_o && rd_ready_i) begin
      rx[rx_n] <= int'(rd_data_o);
      rx_n     <= rx_n + 1;
    end
    if (wr_valid_i && wr_ready_o) begin
      wr_idx <= wr_idx + 1;
      wr_acc <= 1'b1;
    end
    if (done_o) begin
      done_cnt <= done_cnt + 1;
      done_cyc <= cyc;
    end
    if ((rd_valid_o && !rd_ready_i && pop_valid_o) || (wr_ready_o && !wr_valid_i && pop_valid_o))
      stall_err <= stall_err + 1;
    if (hold_p && (rd_data_o != hold_v || !rd_valid_o)) stall_err <= stall_err + 1;
    hold_p <= rd_valid_o && !rd_ready_i;
    hold_v <= rd_data_o;
  end

  // stream partners and register sequencer, driven away from the active edge
  always @(negedge clk) begin
    rd_ready_i <= gaps ? (cyc % 3 != 0) : 1'b1;
    if (!wr_valid_i || wr_acc) begin
      wr_valid_i <= (wr_idx < wr_n) && (!gaps || (cyc % 4 != 1));
      wr_data_i  <= src[wr_idx & 1023][7:0];
    end
    wr_acc <= 1'b0;
    if (sreg_req_o && !sreg_ack_i) begin
      if (ack_w >= 2) begin sreg_ack_i <= 1'b1; ack_w <= 0; end
      else ack_w <= ack_w + 1;
    end else sreg_ack_i <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int k, input int v);
    ex[ex_n] = (k << 8) | v;
    ex_n++;
  endtask

  // expected trace built from the requirement text
  task automatic build_exp(input int mode, input bit wr, input int cnt);
    int ph;
    ex_n = 0;
    ph = wr ? 0 : 1;
    if (!wr) begin
      case (mode)
        0: begin push(0,'h81); push(1,1); push(1,3); push(0,'hC1); end
        1: begin push(0,'h91); push(1,1); push(0,'h10); push(1,3);
                 push(0,'h51); push(1,5); push(0,'hD1); end
        2: begin push(0,'h89); push(1,1); push(1,'h23); push(1,'h21); end
        default: begin if (cnt > 512) push(8,3); push(2,0); push(1,'h24); end
      endcase
      for (int k = 0; k < cnt; k++) begin
        case (mode)
          0: begin push(1,2|ph); push(4,0); push(1,4|ph); push(4,0); end
          1: begin push(1,4|ph); push(4,0); push(5,0); end
          2: begin push(1,'h24|ph); push(6,0); end
          default: push(7,0);
        endcase
        ph = 1 - ph;
      end
      case (mode)
        0, 1: begin push(0,0); push(1,4); end
        2:    begin push(1,6); push(1,4); end
        default: begin push(1,4); push(8,0); end
      endcase
    end else if (mode <= 2) begin
      push(0,'hA1); push(1,1); push(1,3); push(1,1); push(1,5);
      for (int k = 0; k < cnt; k++) begin
        if (k == 0 || src[k] != src[k-1]) push(0, src[k]);
        push(1, 4|ph);
        ph = 1 - ph;
      end
      push(1,7); push(1,4);
    end else begin
      if (cnt < 512) push(8,1);
      push(2,'h40);
      for (int k = 0; k < cnt; k++) push(3, src[k]);
      if (cnt < 512) push(8,0);
    end
  endtask

  task automatic run(input int mode, input bit wr, input int cnt, input bit gp);
    int t;
    lg_n = 0; rx_n = 0; done_cnt = 0; wr_idx = 0;
    wr_n = wr ? cnt : 0; mode_cur = mode; gaps = gp;
    @(negedge clk);
    start_i = 1'b1; dir_i = wr; mode_i = 3'(mode); count_i = 16'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    t = 0;
    while (done_cnt == 0 && t < 30000) begin @(negedge clk); t++; end
    chk(t < 30000, "R13 watchdog: block never completed", t, 30000);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input string tag, input bit wr, input int cnt);
    int bad;
    bad = 0;
    chk(lg_n == ex_n, {tag, " trace length"}, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) if (lg[i] != ex[i] && bad == 0) begin
      bad = 1;
      chk(1'b0, {tag, " trace entry"}, lg[i], ex[i]);
    end
    if (bad == 0) chk(1'b1, tag, 0, 0);
    if (!wr) begin
      bad = 0;
      for (int i = 0; i < cnt; i++) if (rx[i] != (src[i] & 255)) bad++;
      chk(rx_n == cnt && bad == 0, {tag, " read bytes"}, rx_n - bad, cnt);
    end
    chk(done_cnt == 1, "R13 single done pulse", done_cnt, 1);
    chk(done_cyc == last_cyc + 1, "R13 done timing", done_cyc, last_cyc + 1);
    chk(!busy_o, "R13 idle after done", int'(busy_o), 0);
  endtask

  task automatic fill(input int seed);
    for (int k = 0; k < 1024; k++) src[k] = (k * 53 + seed) & 255;
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o, "R1 R13 idle after reset", int'(busy_o), 0);
    chk(!pop_valid_o && !sreg_req_o, "R12 no activity after reset", int'(pop_valid_o), 0);
  endtask

  task automatic t_narrow_reads;
    fill(7);  run(0, 0, 5, 1); build_exp(0, 0, 5); verify("R2 R5 nibble read", 0, 5);
    fill(90); run(1, 0, 4, 1); build_exp(1, 0, 4); verify("R3 5/3 read", 0, 4);
    fill(33); run(2, 0, 3, 0); build_exp(2, 0, 3); verify("R4 byte read", 0, 3);
  endtask

  task automatic t_epp_reads;
    fill(11); run(3, 0, 6, 1);   build_exp(3, 0, 6);   verify("R8 short enhanced read", 0, 6);
    fill(200); run(5, 0, 600, 0); build_exp(5, 0, 600); verify("R8 long enhanced read", 0, 600);
    fill(4);  run(4, 0, 512, 0); build_exp(4, 0, 512); verify("R8 512-byte enhanced read", 0, 512);
  endtask

  task automatic t_narrow_writes;
    fill(0);
    src[0] = 'h11; src[1] = 'h11; src[2] = 'h22; src[3] = 'h22; src[4] = 'h11; src[5] = 'h5A;
    run(0, 1, 6, 1); build_exp(0, 1, 6); verify("R6 R7 nibble-mode write", 1, 6);
    for (int k = 0; k < 4; k++) src[k] = 'hC3;
    run(2, 1, 4, 0); build_exp(2, 1, 4); verify("R7 R5 repeated-byte write", 1, 4);
  endtask

  task automatic t_epp_writes;
    fill(77); run(4, 1, 5, 1);   build_exp(4, 1, 5);   verify("R9 short enhanced write", 1, 5);
    fill(12); run(3, 1, 512, 0); build_exp(3, 1, 512); verify("R9 512-byte enhanced write", 1, 512);
  endtask

  task automatic t_bad_mode;
    lg_n = 0;
    @(negedge clk);
    start_i = 1'b1; dir_i = 1'b0; mode_i = 3'd6; count_i = 16'd4;
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o, "R1 mode 6 start ignored", int'(busy_o), 0);
    repeat (10) @(negedge clk);
    chk(lg_n == 0 && !busy_o, "R1 no operations for mode 6", lg_n, 0);
  endtask

  task automatic t_zero;
    run(2, 0, 0, 0); build_exp(2, 0, 0); verify("R13 zero-length byte read", 0, 0);
    run(5, 0, 0, 0); build_exp(5, 0, 0); verify("R13 R8 zero-length enhanced read", 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_narrow_reads();
    t_epp_reads();
    t_narrow_writes();
    t_epp_writes();
    t_bad_mode();
    t_zero();
    chk(stall_err == 0, "R10 R11 stream stall discipline", stall_err, 0);
    chk(addr_err == 0, "R12 side register address 0x84", addr_err, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL R13 global watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule